// File: doc/BRIEF.md
# Replayable Link Test-Pattern Transmitter

This block is the transmit side of a link test station. A host writes a list of link words into a local buffer over a simple register-write bus. The host then starts playback, and the block presents the stored words to a serial-link transmitter at one word per clock. Each stored word carries two in-band flag bits. They drive the active-low data-available and control-available lines directly, so a receiver can tell which words to capture and where an event ends.

Reading does not consume the stored list. Playback can be restarted from the first word or looped continuously, and the same event can be sent many times without reloading. The host picks the active register with a 2-bit select: 0 is control, 1 is mode, 2 is the buffer. Status is always visible on a read-only port.

Top module: `pattern_tx_port`

## Requirements
- R1: A control write with bit 0 set clears the buffer, the error bit, the mode register and the latched control levels. Afterwards status reads 0x01, `dav_no`, `cav_no` and `port_ctrl_no` are high, and `link_data_o` is zero.
- R2: While mode bit 3 is set, each buffer write (select 2) appends one word. Status bit 0 is empty and status bit 1 is full, at DEPTH words.
- R3: A buffer write while the buffer is full is dropped and sets status bit 3 (overflow). A control write with bit 3 set clears that bit.
- R4: `port_ctrl_no` is the inverse of the latched control bit 31. Words leave only after a start (control bit 5) while `port_ctrl_no` is low. Each released word gives a one-cycle `link_strobe_o`, one word per clock. Status bit 2 is high from the start until playback ends.
- R5: A word with bit 22 set drives `dav_no` low and `cav_no` high. A word with bit 25 set drives `cav_no` low and `dav_no` high.
- R6: With mode bit 7 set, `link_data_o` is word bits 19:0. With it clear, bits 19:16 read as zero.
- R7: After the last stored word is sent without loop-over, the outputs keep presenting that word with its flags, no further strobes occur, and status bit 2 clears.
- R8: Control bit 6 restarts playback from the first stored word.
- R9: With control bit 7 latched, the word after the last stored word is the first stored word, with no gap cycle.
- R10: Control bit 4 stops playback. No strobe follows, and the outputs hold.
- R11: With mode bit 3 clear, buffer writes, start and restart have no effect.
- R12: Control bit 8, with mode bit 3 set, empties the buffer (status 0x01).
- R13: With mode bit 8 set and the overflow bit set, playback is halted and a restart does not start it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Host write strobe |
| host_sel_i | input | 2 | Register select: 0 control, 1 mode, 2 buffer |
| host_data_i | input | 32 | Host write data |
| status_o | output | 8 | {4'b0, overflow, tx active, full, empty} |
| link_data_o | output | 20 | Payload presented to the link transmitter |
| link_strobe_o | output | 1 | One-cycle pulse per released word |
| dav_no | output | 1 | Active-low data available |
| cav_no | output | 1 | Active-low control available |
| port_ctrl_no | output | 1 | Active-low port control |

## Verification
Playback is driven from a table of four words. Three of them carry the data flag with distinct payloads, including one with every payload bit set, and the fourth is an end marker. This separates the two flag encodings and shows whether the upper payload bits are passed or masked. The same table is then replayed in narrow mode, once through restart and once through loop-over. The looped run shows whether the wrap to word zero happens without a gap cycle. Directed cases cover:
- a single data word with no end marker, to confirm the last word is held;
- overflow with and without stop-on-error;
- commands issued to a disabled port;
- a start given while port control is not asserted.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  localparam int PAYLOAD_W = 20;
  localparam int NARROW_W  = 16;
  localparam int DATA_FLAG_BIT = 22;
  localparam int END_FLAG_BIT  = 25;

  // control register bits
  localparam int CB_MRST    = 0;
  localparam int CB_CLRERR  = 3;
  localparam int CB_STOP    = 4;
  localparam int CB_START   = 5;
  localparam int CB_RESTART = 6;
  localparam int CB_LOOP    = 7;
  localparam int CB_CLRBUF  = 8;
  localparam int CB_PORTCTL = 31;
  // mode register bits
  localparam int MB_EN   = 3;
  localparam int MB_WIDE = 7;
  localparam int MB_SOE  = 8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MODE = 2'd1,
    SEL_BUF  = 2'd2
  } host_sel_e;

  typedef struct packed {
    logic                 end_flag;
    logic                 data_flag;
    logic [PAYLOAD_W-1:0] payload;
  } link_word_t;

  typedef struct packed {
    logic enable;
    logic wide;
    logic stop_on_err;
    logic loop_en;
    logic port_ctl;
  } port_cfg_t;

  typedef struct packed {
    logic mrst;
    logic start;
    logic stop;
    logic restart;
    logic clr_buf;
    logic clr_err;
  } port_cmd_t;
endpackage

// File: rtl/ptx_regs.sv
module ptx_regs
  import ptx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [31:0] wr_data_i,
  output port_cfg_t   cfg_o,
  output port_cmd_t   cmd_o,
  output logic        buf_wr_o,
  output link_word_t  buf_word_o
);
  port_cfg_t cfg_q;
  logic ctrl_wr, mode_wr, live;
  logic unused_bits;

  assign ctrl_wr = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign mode_wr = wr_en_i && (wr_sel_i == SEL_MODE);
  assign live    = ctrl_wr && !wr_data_i[CB_MRST];

  always_comb begin
    cmd_o.mrst    = ctrl_wr && wr_data_i[CB_MRST];
    cmd_o.start   = live && wr_data_i[CB_START];
    cmd_o.stop    = live && wr_data_i[CB_STOP];
    cmd_o.restart = live && wr_data_i[CB_RESTART];
    cmd_o.clr_err = live && wr_data_i[CB_CLRERR];
    cmd_o.clr_buf = live && wr_data_i[CB_CLRBUF] && cfg_q.enable;
  end

  assign buf_wr_o              = wr_en_i && (wr_sel_i == SEL_BUF);
  assign buf_word_o.end_flag   = wr_data_i[END_FLAG_BIT];
  assign buf_word_o.data_flag  = wr_data_i[DATA_FLAG_BIT];
  assign buf_word_o.payload    = wr_data_i[PAYLOAD_W-1:0];
  assign unused_bits = ^{wr_data_i[30:26], wr_data_i[24:23], wr_data_i[21:20]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (cmd_o.mrst) begin
      cfg_q <= '0;
    end else begin
      if (ctrl_wr) begin
        cfg_q.loop_en  <= wr_data_i[CB_LOOP];
        cfg_q.port_ctl <= wr_data_i[CB_PORTCTL];
      end
      if (mode_wr) begin
        cfg_q.enable      <= wr_data_i[MB_EN];
        cfg_q.wide        <= wr_data_i[MB_WIDE];
        cfg_q.stop_on_err <= wr_data_i[MB_SOE];
      end
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/ptx_store.sv
module ptx_store
  import ptx_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  link_word_t    word_i,
  input  logic          enable_i,
  input  logic          clear_i,
  input  logic          clr_err_i,
  input  logic [AW-1:0] rd_addr_i,
  output link_word_t    rd_word_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_C   = CW'(1);

  link_word_t    mem [DEPTH];
  logic [CW-1:0] count_q;
  logic          ovf_q;
  logic          accept;

  assign full_o  = (count_q == DEPTH_C);
  assign empty_o = (count_q == '0);
  assign accept  = wr_i && enable_i && !full_o;

  always_ff @(posedge clk_i) begin
    if (accept) mem[count_q[AW-1:0]] <= word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else if (clear_i) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (accept) count_q <= count_q + ONE_C;
      if (clr_err_i) ovf_q <= 1'b0;
      else if (wr_i && enable_i && full_o) ovf_q <= 1'b1;
    end
  end

  assign rd_word_o = mem[rd_addr_i];
  assign count_o   = count_q;
  assign ovf_o     = ovf_q;

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= DEPTH_C);
  // R3
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && enable_i && full_o && !clear_i) |=> ($stable(count_q) && ovf_q));
  // R11
  dis_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !enable_i && !clear_i) |=> $stable(count_q));
endmodule

// File: rtl/ptx_player.sv
module ptx_player
  import ptx_pkg::*;
#(
  parameter int AW = 10,
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          port_ctl_i,
  input  logic          loop_i,
  input  logic          soe_i,
  input  logic          ovf_i,
  input  logic          mrst_i,
  input  logic          clr_buf_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          restart_i,
  input  logic [CW-1:0] count_i,
  input  link_word_t    rd_word_i,
  output logic [AW-1:0] rd_addr_o,
  output link_word_t    word_o,
  output logic          strobe_o,
  output logic          active_o
);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [CW-1:0] rd_q, rd_n, rd_inc;
  logic          run_q, run_n, send, halt;
  link_word_t    word_q;
  logic          strobe_q;

  assign halt   = ovf_i && soe_i;
  assign rd_inc = rd_q + ONE_C;

  always_comb begin
    rd_n  = rd_q;
    run_n = run_q;
    send  = 1'b0;
    if (mrst_i || clr_buf_i) begin
      rd_n  = '0;
      run_n = 1'b0;
    end else if (stop_i || halt) begin
      run_n = 1'b0;
    end else if (restart_i && enable_i) begin
      rd_n  = '0;
      run_n = 1'b1;
    end else if (start_i && enable_i) begin
      run_n = 1'b1;
    end else if (run_q && enable_i && port_ctl_i) begin
      if (rd_q < count_i) begin
        send = 1'b1;
        if (rd_inc == count_i) begin
          if (loop_i) rd_n = '0;
          else begin
            rd_n  = rd_inc;
            run_n = 1'b0;
          end
        end else begin
          rd_n = rd_inc;
        end
      end else begin
        run_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q     <= '0;
      run_q    <= 1'b0;
      word_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      rd_q     <= rd_n;
      run_q    <= run_n;
      strobe_q <= send;
      if (mrst_i)    word_q <= '0;
      else if (send) word_q <= rd_word_i;
    end
  end

  assign rd_addr_o = rd_q[AW-1:0];
  assign word_o    = word_q;
  assign strobe_o  = strobe_q;
  assign active_o  = run_q;

  // R4
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |-> $past(port_ctl_i && enable_i));
  // R10
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !run_q);
  // R13
  halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |=> !run_q);
endmodule

// File: rtl/pattern_tx_port.sv
module pattern_tx_port
  import ptx_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 host_wr_i,
  input  logic [1:0]           host_sel_i,
  input  logic [31:0]          host_data_i,
  output logic [7:0]           status_o,
  output logic [PAYLOAD_W-1:0] link_data_o,
  output logic                 link_strobe_o,
  output logic                 dav_no,
  output logic                 cav_no,
  output logic                 port_ctrl_no
);
  port_cfg_t     cfg;
  port_cmd_t     cmd;
  logic          buf_wr, full, empty, ovf, active;
  link_word_t    buf_word, rd_word, out_word;
  logic [AW-1:0] rd_addr;
  logic [CW-1:0] count;

  ptx_regs u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(host_wr_i), .wr_sel_i(host_sel_i), .wr_data_i(host_data_i),
    .cfg_o(cfg), .cmd_o(cmd), .buf_wr_o(buf_wr), .buf_word_o(buf_word)
  );

  ptx_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .wr_i(buf_wr), .word_i(buf_word), .enable_i(cfg.enable),
    .clear_i(cmd.mrst || cmd.clr_buf), .clr_err_i(cmd.clr_err),
    .rd_addr_i(rd_addr), .rd_word_o(rd_word), .count_o(count),
    .full_o(full), .empty_o(empty), .ovf_o(ovf)
  );

  ptx_player #(.AW(AW)) u_player (
    .clk_i, .rst_ni,
    .enable_i(cfg.enable), .port_ctl_i(cfg.port_ctl), .loop_i(cfg.loop_en),
    .soe_i(cfg.stop_on_err), .ovf_i(ovf),
    .mrst_i(cmd.mrst), .clr_buf_i(cmd.clr_buf), .start_i(cmd.start),
    .stop_i(cmd.stop), .restart_i(cmd.restart),
    .count_i(count), .rd_word_i(rd_word), .rd_addr_o(rd_addr),
    .word_o(out_word), .strobe_o(link_strobe_o), .active_o(active)
  );

  assign link_data_o  = cfg.wide ? out_word.payload
                      : {{(PAYLOAD_W-NARROW_W){1'b0}}, out_word.payload[NARROW_W-1:0]};
  assign dav_no       = !out_word.data_flag;
  assign cav_no       = !out_word.end_flag;
  assign port_ctrl_no = !cfg.port_ctl;
  assign status_o     = {4'b0, ovf, active, full, empty};

  // R1
  mrst_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd.mrst |=> (status_o == 8'h01 && dav_no && cav_no && port_ctrl_no));
endmodule

// File: tb/pattern_tx_port_test.sv
module pattern_tx_port_test;
  localparam int DEPTH = 4;
  localparam logic [3:0][31:0] VEC_WORD = {32'h0200_0000, 32'h004F_FFFF, 32'h0041_2345, 32'h004A_BCDE};
  localparam logic [3:0][19:0] VEC_PAY  = {20'h00000, 20'hFFFFF, 20'h12345, 20'hABCDE};
  localparam logic [3:0]       VEC_DAV  = 4'b1000;
  localparam logic [3:0]       VEC_CAV  = 4'b0111;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_data = '0;
  logic [7:0]  status;
  logic [19:0] link_data;
  logic        strobe, dav_n, cav_n, pctl_n;
  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  pattern_tx_port #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .host_wr_i(host_wr), .host_sel_i(host_sel),
    .host_data_i(host_data), .status_o(status), .link_data_o(link_data),
    .link_strobe_o(strobe), .dav_no(dav_n), .cav_no(cav_n), .port_ctrl_no(pctl_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_data = data;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic chk_word(input string req, input int idx, input logic narrow);
    logic [19:0] exp_pay;
    exp_pay = narrow ? {4'h0, VEC_PAY[idx][15:0]} : VEC_PAY[idx];
    chk({req, " payload"}, {12'h0, link_data}, {12'h0, exp_pay});
    chk("R5 dav", {31'h0, dav_n}, {31'h0, VEC_DAV[idx]});
    chk("R5 cav", {31'h0, cav_n}, {31'h0, VEC_CAV[idx]});
    chk("R4 strobe", {31'h0, strobe}, 32'h1);
  endtask

  initial begin
    logic [19:0] held;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", {24'h0, status}, 32'h01);
    chk("R1 flags", {29'h0, dav_n, cav_n, pctl_n}, 32'h7);
    chk("R1 strobe", {31'h0, strobe}, 32'h0);

    host_write(2'd1, 32'h88);
    for (int i = 0; i < 4; i++) host_write(2'd2, VEC_WORD[i]);
    chk("R2 full", {24'h0, status}, 32'h02);
    host_write(2'd2, 32'h0047_7777);
    chk("R3 overflow", {24'h0, status}, 32'h0A);
    host_write(2'd0, 32'h8);
    chk("R3 clear err", {24'h0, status}, 32'h02);

    // R4 start without port control
    host_write(2'd0, 32'h20);
    chk("R4 active", {24'h0, status}, 32'h06);
    chk("R4 pctl off", {31'h0, pctl_n}, 32'h1);
    @(negedge clk);
    chk("R4 no strobe", {31'h0, strobe}, 32'h0);
    host_write(2'd0, 32'h8000_0000);
    chk("R4 pctl on", {31'h0, pctl_n}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_word("R6 wide", i, 1'b0);
    end
    @(negedge clk);
    // R7 hold after end
    chk("R7 strobe", {31'h0, strobe}, 32'h0);
    chk("R7 cav held", {30'h0, dav_n, cav_n}, 32'h2);
    chk("R7 status", {24'h0, status}, 32'h02);

    // R8 restart, narrow mode
    host_write(2'd1, 32'h08);
    host_write(2'd0, 32'h8000_0040);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_word("R8 R6 narrow", i, 1'b1);
    end

    // R9 loop-over
    host_write(2'd0, 32'h8000_00C0);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      chk_word("R9 loop", i % 4, 1'b1);
    end

    // R10 stop
    host_write(2'd0, 32'h8000_0010);
    @(negedge clk);
    held = link_data;
    chk("R10 strobe", {31'h0, strobe}, 32'h0);
    repeat (2) @(negedge clk);
    chk("R10 hold", {12'h0, link_data}, {12'h0, held});
    chk("R10 status", {24'h0, status}, 32'h02);

    // R12 clear buffer
    host_write(2'd0, 32'h100);
    chk("R12 empty", {24'h0, status}, 32'h01);

    // R11 disabled port
    host_write(2'd1, 32'h00);
    host_write(2'd2, 32'h0041_1111);
    chk("R11 write ignored", {24'h0, status}, 32'h01);
    host_write(2'd0, 32'h8000_0020);
    @(negedge clk);
    chk("R11 start ignored", {24'h0, status}, 32'h01);
    chk("R11 no strobe", {31'h0, strobe}, 32'h0);

    // R7 no end marker: last data word keeps being presented
    host_write(2'd1, 32'h88);
    host_write(2'd2, 32'h0045_5555);
    host_write(2'd0, 32'h8000_0020);
    @(negedge clk);
    chk("R7 first send", {11'h0, strobe, link_data}, {11'h0, 1'b1, 20'h55555});
    repeat (3) @(negedge clk);
    chk("R7 held word", {11'h0, strobe, link_data}, {11'h0, 1'b0, 20'h55555});
    chk("R7 held flags", {30'h0, dav_n, cav_n}, 32'h1);

    // R13 stop-on-error
    host_write(2'd1, 32'h188);
    for (int i = 0; i < 4; i++) host_write(2'd2, 32'h0040_0001 + i);
    chk("R13 ovf set", {24'h0, status}, 32'h0A);
    host_write(2'd0, 32'h8000_0040);
    repeat (2) begin
      @(negedge clk);
      chk("R13 halted strobe", {31'h0, strobe}, 32'h0);
    end
    chk("R13 halted status", {24'h0, status}, 32'h0A);

    // R1 master reset from busy state
    host_write(2'd0, 32'h1);
    chk("R1 mrst status", {24'h0, status}, 32'h01);
    chk("R1 mrst flags", {29'h0, dav_n, cav_n, pctl_n}, 32'h7);
    chk("R1 mrst data", {12'h0, link_data}, 32'h0);
    host_write(2'd2, 32'h0040_0002);
    chk("R1 mode cleared", {24'h0, status}, 32'h01);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule